// File: doc/BRIEF.md
# Byte-Alterable Nonvolatile Memory with Page Load and Busy Polling

This block is a clocked behavioural model of an 8K x 8 parallel nonvolatile memory. A host drives three active-low strobes (chip select, output enable and write strobe), a 13-bit address and a shared 8-bit data bus. The block samples all of them on the system clock. Reads return array contents. A write strobe pulse loads one byte into a 64-byte page buffer. Further strobes that name the same page add more bytes to the buffer. After a quiet interval with no new strobe, a self-timed programming cycle copies the loaded bytes into the array.

While that cycle runs, the array cannot be reached. Any read instead returns a busy word. Its top bit is the inverse of the top bit of the last byte accepted, and its next bit flips on every new read. A host polls the busy word until the top bit matches the byte it wrote, or until the flipping stops. Both timing windows are parameters counted in clock cycles, so a test can shorten them. The array is a plain register memory with no wear or analog behaviour.

Top module: `eeprom_page_writer`

## Requirements
- R1: The block drives the data bus only while chip select and output enable are both low. Outside the programming cycle it then drives the array byte at the sampled address. At all other times it leaves the bus released.
- R2: A write is recognised only while chip select and write strobe are both low and output enable is high. The address is taken when that condition begins. The data is the last value sampled before the condition ends. A strobe with chip select high writes nothing.
- R3: Address bits 12..6 select the page and bits 5..0 select the byte within it. One page load accepts any set of 1 to 64 bytes of one page, including offsets 0 and 63, and all of them reach the array.
- R4: A write during a page load whose bits 12..6 differ from those of the load's first write is dropped. It sets `page_err` to 1. `page_err` stays set until the first write of the next load clears it.
- R5: Programming begins after LOAD_TMO clock cycles pass with no write in progress. Each new write restarts that count, so a chain of writes with short gaps keeps the load open for any total length.
- R6: During programming, a read at any address returns the inverse of bit 7 of the last accepted byte on data bit 7.
- R7: During programming, data bit 6 takes opposite values on two successive reads. Data bits 5..0 return bits 5..0 of the last accepted byte.
- R8: Programming lasts PROG_CYC cycles, with PROG_CYC at least 64. After it ends, reads return the programmed bytes.
- R9: Writes issued during programming change neither the array nor the last accepted byte.
- R10: After reset the block is idle, the bus is released and `page_err` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_en_n | input | 1 | Active-low output enable |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 13 | Byte address; bits 12..6 give the page |
| data | inout | 8 | Shared data bus |
| page_err | output | 1 | Set when a write naming another page is dropped from a load |

## Verification
A wrong load timer shows up at the ports within one write-to-read turnaround. A read that should still return array data returns the busy word instead, or the reverse. A stale page register or valid mask shows only after programming ends, as wrong read-back data for the affected bytes. A wrong last-byte or toggle register shows on the very next busy read, through bit 7 or through bit 6 failing to alternate.

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter int ADDR_W   = 13,
  parameter int DATA_W   = 8,
  parameter int PAGE_W   = 6,
  parameter int LOAD_TMO = 20000,
  parameter int PROG_CYC = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_en_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  inout  wire  [DATA_W-1:0] data,
  output logic              page_err
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PBYTES = 1 << PAGE_W;
  localparam int PG_W   = ADDR_W - PAGE_W;
  localparam int TW     = $clog2(LOAD_TMO + 1);
  localparam int PW     = $clog2(PROG_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_PROG} st_t;

  st_t               state;
  logic              cs_q, oe_q, we_q, wr_prev, rd_prev, tog;
  logic [ADDR_W-1:0] a_q, wa;
  logic [DATA_W-1:0] d_q, wd, last;
  logic [PG_W-1:0]   pg;
  logic [PBYTES-1:0] vld;
  logic [TW-1:0]     tmr;
  logic [PW-1:0]     pcnt;
  logic [DATA_W-1:0] pbuf [PBYTES];
  logic [DATA_W-1:0] mem  [DEPTH];

  wire wr_act   = !cs_q && !we_q && oe_q;
  wire rd_act   = !cs_q && !oe_q;
  wire commit   = wr_prev && !wr_act;
  wire rd_end   = rd_prev && !rd_act;
  wire same_pg  = wa[ADDR_W-1:PAGE_W] == pg;
  wire accept   = commit && (state == S_IDLE || (state == S_LOAD && same_pg));
  wire drop     = commit && state == S_LOAD && !same_pg;
  wire [PAGE_W-1:0] pidx = pcnt[PAGE_W-1:0];

  wire [DATA_W-1:0] status = {~last[DATA_W-1], tog, last[DATA_W-3:0]};
  wire [DATA_W-1:0] dout   = (state == S_PROG) ? status : mem[a_q];
  assign data = rd_act ? dout : {DATA_W{1'bz}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q <= 1'b1; oe_q <= 1'b1; we_q <= 1'b1;
      a_q <= '0; d_q <= '0; wr_prev <= 1'b0; rd_prev <= 1'b0;
    end else begin
      cs_q <= cs_n; oe_q <= rd_en_n; we_q <= wr_n;
      a_q <= addr; d_q <= data;
      wr_prev <= wr_act; rd_prev <= rd_act;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wa <= '0; wd <= '0;
    end else begin
      if (wr_act && !wr_prev) wa <= a_q;
      if (wr_act) wd <= d_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; pg <= '0; vld <= '0; last <= '0;
      tmr <= '0; pcnt <= '0; tog <= 1'b0; page_err <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (commit) begin
          pg       <= wa[ADDR_W-1:PAGE_W];
          vld      <= PBYTES'(1) << wa[PAGE_W-1:0];
          last     <= wd;
          tmr      <= '0;
          page_err <= 1'b0;
          state    <= S_LOAD;
        end
        S_LOAD: begin
          if (wr_act) tmr <= '0;
          else if (tmr == TW'(LOAD_TMO - 1)) begin
            state <= S_PROG;
            pcnt  <= '0;
          end else tmr <= tmr + 1'b1;
          if (accept) begin
            vld[wa[PAGE_W-1:0]] <= 1'b1;
            last <= wd;
          end
          if (drop) page_err <= 1'b1;
        end
        S_PROG: begin
          pcnt <= pcnt + 1'b1;
          if (rd_end) tog <= ~tog;
          if (pcnt == PW'(PROG_CYC - 1)) begin
            state <= S_IDLE;
            vld   <= '0;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (accept) pbuf[wa[PAGE_W-1:0]] <= wd;

  always_ff @(posedge clk)
    if (state == S_PROG && pcnt < PW'(PBYTES) && vld[pidx])
      mem[{pg, pidx}] <= pbuf[pidx];

  AST_LOAD_EXPIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LOAD && !wr_act && tmr == TW'(LOAD_TMO - 1)) |=> state == S_PROG); // R5
  AST_PAGE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> page_err && $stable(pg) && $stable(last)); // R4
  AST_PROG_IGNORES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PROG && commit) |=> $stable(last)); // R9
  AST_BUSY_BIT7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PROG && rd_act) |-> data[DATA_W-1] == ~last[DATA_W-1]); // R6
  AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PROG && rd_end) |=> tog != $past(tog)); // R7
  AST_PROG_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PROG && pcnt == PW'(PROG_CYC - 1)) |=> state == S_IDLE && vld == '0); // R8
endmodule

// File: tb/eeprom_page_writer_tb.sv
`timescale 1ns/1ps
module eeprom_page_writer_tb_top;
  localparam int TMO = 20;
  localparam int PRG = 100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [12:0] addr = '0;
  logic [7:0] bdat = '0;
  logic drv = 1'b0;
  logic page_err;
  wire  [7:0] data;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  assign data = drv ? bdat : 8'hzz;
  always #2.5 clk = ~clk;

  eeprom_page_writer #(.LOAD_TMO(TMO), .PROG_CYC(PRG)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_en_n(oe_n), .wr_n(we_n),
    .addr(addr), .data(data), .page_err(page_err));

  // {address, data}: page 5, offsets 0,1,2,17,33,40,62,63
  localparam logic [20:0] VEC [8] = '{
    {13'h0140, 8'h11}, {13'h0141, 8'h82}, {13'h0142, 8'h3F}, {13'h0151, 8'hC4},
    {13'h0161, 8'h55}, {13'h0168, 8'hAA}, {13'h017E, 8'h7E}, {13'h017F, 8'hE1}};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d, input bit sel = 1'b1,
                    input logic [12:0] a2 = 13'h0, input bit move = 1'b0);
    @(negedge clk);
    addr = a; bdat = d; drv = 1'b1; cs_n = !sel; we_n = 1'b0;
    @(negedge clk);
    if (move) addr = a2;
    repeat (2) @(negedge clk);
    we_n = 1'b1; cs_n = 1'b1;
    repeat (2) @(negedge clk);
    drv = 1'b0;
  endtask

  task automatic rd(input logic [12:0] a, output logic [7:0] q);
    @(negedge clk);
    addr = a; cs_n = 1'b0; oe_n = 1'b0;
    repeat (3) @(negedge clk);
    q = data;
    oe_n = 1'b1; cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] q, q2;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 / R1: bus released after reset: the bench's own pattern reads back intact
    bdat = 8'h00; drv = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 bus idle", data, 8'h00);
    chk("R10 page_err", {7'd0, page_err}, 8'h00);
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 no drive with output enable high", data, 8'h00);
    cs_n = 1'b1; drv = 1'b0;

    // single byte then busy polling
    wr(13'h0100, 8'h3C);
    repeat (TMO + 4) @(negedge clk);
    rd(13'h0000, q);
    chk("R6 busy bit7", {q[7], 7'd0}, 8'h80);
    chk("R7 low bits", {2'b00, q[5:0]}, 8'h3C);
    rd(13'h1FFF, q2);
    chk("R7 bit6 flips", {7'd0, q2[6]}, {7'd0, ~q[6]});
    wr(13'h0100, 8'h99);  // R9: during programming
    rd(13'h0000, q);
    chk("R9 last byte unchanged", {q[7], 7'd0}, 8'h80);
    repeat (PRG + 10) @(negedge clk);
    rd(13'h0100, q);
    chk("R8 data after programming", q, 8'h3C);
    rd(13'h0100, q);
    chk("R9 array unchanged", q, 8'h3C);

    // R3 page load from the vector table, then a foreign page write
    foreach (VEC[i]) wr(VEC[i][20:8], VEC[i][7:0]);
    chk("R4 no flag for same page", {7'd0, page_err}, 8'h00);
    wr(13'h0185, 8'hF0);
    chk("R4 foreign page flagged", {7'd0, page_err}, 8'h01);
    repeat (TMO + PRG + 20) @(negedge clk);
    foreach (VEC[i]) begin
      rd(VEC[i][20:8], q);
      chk("R3 page byte", q, VEC[i][7:0]);
    end
    chk("R4 flag held", {7'd0, page_err}, 8'h01);

    // R5 restart: the gap before the second write alone would nearly expire
    wr(13'h0200, 8'hC3);
    chk("R4 flag cleared by new load", {7'd0, page_err}, 8'h00);
    repeat (TMO - 6) @(negedge clk);
    wr(13'h0201, 8'h5A);
    rd(13'h0100, q);
    chk("R5 still loading", q, 8'h3C);
    repeat (TMO + PRG + 20) @(negedge clk);
    rd(13'h0200, q);
    chk("R5 first byte", q, 8'hC3);
    rd(13'h0201, q);
    chk("R5 second byte", q, 8'h5A);

    // R2: address taken at strobe start; strobe with chip select high ignored
    wr(13'h0300, 8'h6E, 1'b1, 13'h0301, 1'b1);
    wr(13'h0100, 8'h77, 1'b0);
    repeat (TMO + PRG + 20) @(negedge clk);
    rd(13'h0300, q);
    chk("R2 address at strobe start", q, 8'h6E);
    rd(13'h0100, q);
    chk("R2 chip select high blocks write", q, 8'h3C);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule